// File: doc/BRIEF.md
# Mode-Banked General Register File

This block is the general register file of a processor core that runs in several privilege modes. It holds sixteen 32-bit architectural registers and has two combinational read ports and one write port. Registers 8 to 14 are shadowed per mode, so an exception handler can use its own stack pointer and link register without first saving the interrupted program's copies. The fast-interrupt mode also has private copies of registers 8 to 12, so its handler can start work with no register spills.

The core drives the requested mode on `mode_i` and pulses `mode_chg_i`. On that clock edge, the registers that were visible are retired into the outgoing mode's bank, and the incoming mode's bank becomes visible. Registers 0 to 7 and the program counter (register 15) are the same storage in every mode. If the core requests a mode encoding that is not defined, the block sets a sticky error flag and leaves the current mode and every bank unchanged.

Top module: `banked_regfile`

## Requirements
- R1: After reset, every register reads zero in every mode, `mode_o` is user mode (0x10) and `mode_err_o` is low.
- R2: Registers 0 to 7 and register 15 are one storage shared by all modes. A value written in any mode reads back unchanged in every other mode.
- R3: User mode (0x10) and system mode (0x1F) see the same copies of registers 8 to 14.
- R4: Fast-interrupt mode (0x11) has its own copies of registers 8 to 14. Writes to them in that mode are invisible to all other modes, and writes made in other modes are invisible to it.
- R5: Interrupt (0x12), supervisor (0x13), abort (0x17) and undefined (0x1B) modes each have a private register 13 and register 14. None of these copies is shared with any other mode.
- R6: In interrupt, supervisor, abort and undefined modes, registers 8 to 12 are the same storage as user mode's registers 8 to 12.
- R7: When `mode_chg_i` is high with a defined encoding, `mode_o` and the visible bank change at that clock edge. When `mode_chg_i` is low, `mode_o` holds its value whatever `mode_i` carries.
- R8: A write on the same edge as a legal mode change lands in the incoming mode's view of the register file.
- R9: When `mode_chg_i` is high with an undefined encoding, `mode_err_o` rises on that edge and stays high until reset. The mode and all banks stay unchanged, and a write on the same edge lands in the current mode's view.
- R10: Both read ports return the addressed register combinationally for the current mode. A write becomes visible after its clock edge. Nothing is stored while `wr_en_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 5 | Requested mode encoding |
| mode_chg_i | input | 1 | Apply `mode_i` on this edge |
| wr_en_i | input | 1 | Write enable |
| wr_addr_i | input | 4 | Architectural register to write |
| wr_data_i | input | 32 | Write data |
| rd_a_addr_i | input | 4 | Read port A register number |
| rd_a_data_o | output | 32 | Read port A data |
| rd_b_addr_i | input | 4 | Read port B register number |
| rd_b_data_o | output | 32 | Read port B data |
| mode_o | output | 5 | Current mode |
| mode_err_o | output | 1 | Sticky undefined-mode flag |

## Verification
The hardest thing to show from the ports is that a shadow copy stayed untouched while its mode was inactive. The only way to observe a bank is to re-enter its mode. The stimulus therefore plants distinct values in the fast-interrupt bank, the user bank and several exception-mode banks. It then walks through every mode and returns to each earlier one, which exposes any leak between banks. Writes placed on the same edge as a legal mode change, and on the same edge as an undefined one, cover the two cases where the write view depends on the swap decision.

// File: rtl/bank_rf_pkg.sv
package bank_rf_pkg;
  localparam int unsigned NUM_ARCH  = 16;
  localparam int unsigned ADDR_W    = $clog2(NUM_ARCH);
  localparam int unsigned MODE_W    = 5;
  localparam int unsigned FIQ_LO    = 8;
  localparam int unsigned PRIV_LO   = 13;
  localparam int unsigned BANK_HI   = 14;
  localparam int unsigned FIQ_CNT   = BANK_HI - FIQ_LO + 1;
  localparam int unsigned PRIV_CNT  = BANK_HI - PRIV_LO + 1;
  localparam int unsigned N_PRIV    = 4;
  localparam int unsigned N_SLOTS   = NUM_ARCH + FIQ_CNT + N_PRIV * PRIV_CNT;
  localparam int unsigned SLOT_W    = $clog2(N_SLOTS);

  typedef enum logic [MODE_W-1:0] {
    MODE_USR = 5'h10,
    MODE_FIQ = 5'h11,
    MODE_IRQ = 5'h12,
    MODE_SVC = 5'h13,
    MODE_ABT = 5'h17,
    MODE_UND = 5'h1B,
    MODE_SYS = 5'h1F
  } mode_e;

  // private-r13/r14 banks must stay contiguous from BANK_IRQ
  typedef enum logic [2:0] {
    BANK_USR = 3'd0,
    BANK_FIQ = 3'd1,
    BANK_IRQ = 3'd2,
    BANK_SVC = 3'd3,
    BANK_ABT = 3'd4,
    BANK_UND = 3'd5
  } bank_e;

  function automatic logic mode_known(logic [MODE_W-1:0] m);
    case (m)
      MODE_USR, MODE_FIQ, MODE_IRQ, MODE_SVC,
      MODE_ABT, MODE_UND, MODE_SYS: return 1'b1;
      default:                      return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/bank_rf_mode_decode.sv
module bank_rf_mode_decode
  import bank_rf_pkg::*;
(
  input  logic [MODE_W-1:0] mode_i,
  output bank_e             bank_o,
  output logic              known_o
);
  always_comb begin
    known_o = 1'b1;
    bank_o  = BANK_USR;
    case (mode_i)
      MODE_USR, MODE_SYS: bank_o = BANK_USR;
      MODE_FIQ:           bank_o = BANK_FIQ;
      MODE_IRQ:           bank_o = BANK_IRQ;
      MODE_SVC:           bank_o = BANK_SVC;
      MODE_ABT:           bank_o = BANK_ABT;
      MODE_UND:           bank_o = BANK_UND;
      default:            known_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/bank_rf_slot_map.sv
module bank_rf_slot_map
  import bank_rf_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  input  bank_e             bank_i,
  output logic [SLOT_W-1:0] slot_o
);
  always_comb begin
    int a;
    int b;
    int idx;
    a   = int'(addr_i);
    b   = int'(bank_i);
    idx = a;
    if (bank_i == BANK_FIQ && a >= int'(FIQ_LO) && a <= int'(BANK_HI))
      idx = int'(NUM_ARCH) + a - int'(FIQ_LO);
    else if (b >= int'(BANK_IRQ) && a >= int'(PRIV_LO) && a <= int'(BANK_HI))
      idx = int'(NUM_ARCH + FIQ_CNT) + (b - int'(BANK_IRQ)) * int'(PRIV_CNT)
            + a - int'(PRIV_LO);
    slot_o = SLOT_W'(idx);
  end
endmodule

// File: rtl/bank_rf_storage.sv
module bank_rf_storage #(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned N_SLOTS = 31,
  localparam int unsigned SLOT_W = $clog2(N_SLOTS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [SLOT_W-1:0] wslot_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [SLOT_W-1:0] rslot_a_i,
  output logic [DATA_W-1:0] rdata_a_o,
  input  logic [SLOT_W-1:0] rslot_b_i,
  output logic [DATA_W-1:0] rdata_b_o
);
  logic [DATA_W-1:0] slot_val [N_SLOTS];

  for (genvar s = 0; s < int'(N_SLOTS); s++) begin : g_slot
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              q <= '0;
      else if (we_i && wslot_i == SLOT_W'(s))   q <= wdata_i;
    end
    assign slot_val[s] = q;
  end

  assign rdata_a_o = slot_val[rslot_a_i];
  assign rdata_b_o = slot_val[rslot_b_i];
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import bank_rf_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [4:0]        mode_i,
  input  logic              mode_chg_i,
  input  logic              wr_en_i,
  input  logic [3:0]        wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [3:0]        rd_a_addr_i,
  output logic [DATA_W-1:0] rd_a_data_o,
  input  logic [3:0]        rd_b_addr_i,
  output logic [DATA_W-1:0] rd_b_data_o,
  output logic [4:0]        mode_o,
  output logic              mode_err_o
);
  localparam int unsigned N_PORTS = 3;

  logic [MODE_W-1:0] mode_q;
  bank_e             bank_q;
  logic              err_q;
  bank_e             req_bank;
  logic              req_known;
  logic              swap;
  bank_e             wr_bank;

  bank_rf_mode_decode u_dec (
    .mode_i (mode_i),
    .bank_o (req_bank),
    .known_o(req_known)
  );

  assign swap    = mode_chg_i & req_known;
  // same-edge write targets the view that exists after the edge
  assign wr_bank = swap ? req_bank : bank_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_USR;
      bank_q <= BANK_USR;
      err_q  <= 1'b0;
    end else if (mode_chg_i) begin
      if (req_known) begin
        mode_q <= mode_i;
        bank_q <= req_bank;
      end else begin
        err_q  <= 1'b1;
      end
    end
  end

  logic [ADDR_W-1:0] map_addr [N_PORTS];
  bank_e             map_bank [N_PORTS];
  logic [SLOT_W-1:0] map_slot [N_PORTS];

  assign map_addr[0] = rd_a_addr_i;
  assign map_addr[1] = rd_b_addr_i;
  assign map_addr[2] = wr_addr_i;
  assign map_bank[0] = bank_q;
  assign map_bank[1] = bank_q;
  assign map_bank[2] = wr_bank;

  for (genvar p = 0; p < int'(N_PORTS); p++) begin : g_map
    bank_rf_slot_map u_map (
      .addr_i(map_addr[p]),
      .bank_i(map_bank[p]),
      .slot_o(map_slot[p])
    );
  end

  bank_rf_storage #(
    .DATA_W (DATA_W),
    .N_SLOTS(N_SLOTS)
  ) u_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (wr_en_i),
    .wslot_i  (map_slot[2]),
    .wdata_i  (wr_data_i),
    .rslot_a_i(map_slot[0]),
    .rdata_a_o(rd_a_data_o),
    .rslot_b_i(map_slot[1]),
    .rdata_b_o(rd_b_data_o)
  );

  assign mode_o     = mode_q;
  assign mode_err_o = err_q;
endmodule

// File: rtl/bank_rf_chk.sv
module bank_rf_chk
  import bank_rf_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [4:0]        mode_i,
  input logic              mode_chg_i,
  input logic              wr_en_i,
  input logic [3:0]        rd_a_addr_i,
  input logic [DATA_W-1:0] rd_a_data_o,
  input logic [4:0]        mode_o,
  input logic              mode_err_o
);
  // R7
  mode_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_chg_i && mode_known(mode_i)) |=> (mode_o == $past(mode_i)));

  // R7
  mode_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_chg_i |=> $stable(mode_o));

  // R9
  bad_mode_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_chg_i && !mode_known(mode_i)) |=> (mode_err_o && $stable(mode_o)));

  // R9
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_err_o |=> mode_err_o);

  // R9
  mode_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_known(mode_o));

  // R2
  low_regs_unbanked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i && rd_a_addr_i < 4'd8) |=>
      ((rd_a_addr_i != $past(rd_a_addr_i)) || (rd_a_data_o == $past(rd_a_data_o))));
endmodule

bind banked_regfile bank_rf_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mode_i     (mode_i),
  .mode_chg_i (mode_chg_i),
  .wr_en_i    (wr_en_i),
  .rd_a_addr_i(rd_a_addr_i),
  .rd_a_data_o(rd_a_data_o),
  .mode_o     (mode_o),
  .mode_err_o (mode_err_o)
);

// File: tb/banked_regfile_test.sv
module banked_regfile_test;
  localparam int CLK_P = 10;
  localparam int N_VEC = 21;

  typedef struct packed {
    logic        chg;
    logic [4:0]  mode;
    logic        we;
    logic [3:0]  wa;
    logic [31:0] wd;
    logic [3:0]  ra;
    logic [31:0] ea;
    logic [3:0]  rb;
    logic [31:0] eb;
    logic [4:0]  em;
    logic        ee;
    logic [3:0]  req;
  } vec_t;

  // each row: apply, clock once, then check both reads, mode and error flag
  localparam vec_t TBL [N_VEC] = '{
    '{1'b0,5'h10,1'b1,4'd8, 32'hA8,  4'd8, 32'hA8,  4'd0, 32'h0,   5'h10,1'b0,4'd10}, // R10
    '{1'b0,5'h10,1'b1,4'd13,32'h0D,  4'd13,32'h0D,  4'd8, 32'hA8,  5'h10,1'b0,4'd10}, // R10
    '{1'b0,5'h10,1'b1,4'd0, 32'h55,  4'd0, 32'h55,  4'd15,32'h0,   5'h10,1'b0,4'd2},  // R2
    '{1'b0,5'h10,1'b1,4'd15,32'hF0,  4'd15,32'hF0,  4'd0, 32'h55,  5'h10,1'b0,4'd2},  // R2
    '{1'b1,5'h11,1'b1,4'd8, 32'h1188,4'd8, 32'h1188,4'd13,32'h0,   5'h11,1'b0,4'd8},  // R8
    '{1'b0,5'h11,1'b1,4'd13,32'h11DD,4'd13,32'h11DD,4'd0, 32'h55,  5'h11,1'b0,4'd4},  // R4
    '{1'b0,5'h11,1'b0,4'd0, 32'h0,   4'd15,32'hF0,  4'd14,32'h0,   5'h11,1'b0,4'd2},  // R2
    '{1'b1,5'h1F,1'b0,4'd0, 32'h0,   4'd8, 32'hA8,  4'd13,32'h0D,  5'h1F,1'b0,4'd3},  // R3
    '{1'b1,5'h12,1'b1,4'd14,32'h12EE,4'd14,32'h12EE,4'd8, 32'hA8,  5'h12,1'b0,4'd6},  // R6
    '{1'b0,5'h12,1'b1,4'd9, 32'h99,  4'd9, 32'h99,  4'd13,32'h0,   5'h12,1'b0,4'd6},  // R6
    '{1'b1,5'h13,1'b1,4'd13,32'h13DD,4'd13,32'h13DD,4'd9, 32'h99,  5'h13,1'b0,4'd5},  // R5
    '{1'b1,5'h17,1'b0,4'd0, 32'h0,   4'd13,32'h0,   4'd14,32'h0,   5'h17,1'b0,4'd5},  // R5
    '{1'b1,5'h1B,1'b1,4'd13,32'h1BDD,4'd13,32'h1BDD,4'd9, 32'h99,  5'h1B,1'b0,4'd5},  // R5
    '{1'b1,5'h12,1'b0,4'd0, 32'h0,   4'd14,32'h12EE,4'd13,32'h0,   5'h12,1'b0,4'd5},  // R5
    '{1'b1,5'h13,1'b0,4'd0, 32'h0,   4'd13,32'h13DD,4'd8, 32'hA8,  5'h13,1'b0,4'd5},  // R5
    '{1'b1,5'h11,1'b0,4'd0, 32'h0,   4'd8, 32'h1188,4'd9, 32'h0,   5'h11,1'b0,4'd4},  // R4
    '{1'b1,5'h10,1'b0,4'd0, 32'h0,   4'd9, 32'h99,  4'd13,32'h0D,  5'h10,1'b0,4'd6},  // R6
    '{1'b0,5'h11,1'b0,4'd0, 32'hBAD, 4'd0, 32'h55,  4'd14,32'h0,   5'h10,1'b0,4'd7},  // R7, R10
    '{1'b1,5'h00,1'b1,4'd13,32'h777, 4'd13,32'h777, 4'd8, 32'hA8,  5'h10,1'b1,4'd9},  // R9
    '{1'b1,5'h1A,1'b0,4'd0, 32'h0,   4'd13,32'h777, 4'd0, 32'h55,  5'h10,1'b1,4'd9},  // R9
    '{1'b1,5'h1F,1'b0,4'd0, 32'h0,   4'd13,32'h777, 4'd14,32'h0,   5'h1F,1'b1,4'd9}   // R9
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [4:0]  mode_i = 5'h10;
  logic        mode_chg_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [3:0]  wr_addr_i = '0;
  logic [31:0] wr_data_i = '0;
  logic [3:0]  rd_a_addr_i = '0;
  logic [3:0]  rd_b_addr_i = '0;
  logic [31:0] rd_a_data_o, rd_b_data_o;
  logic [4:0]  mode_o;
  logic        mode_err_o;

  int checks = 0;
  int errors = 0;

  banked_regfile uut (.*);

  always #(CLK_P/2) clk_i = ~clk_i;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    mode_chg_i = 1'b0;
    wr_en_i    = 1'b0;
  endtask

  initial begin
    #(CLK_P * 50000);
    errors++;
    checks++;
    $display("FAIL watchdog act=running exp=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1: reset state, all registers zero through both ports
    chk("R1 mode", {27'b0, mode_o}, 32'h10);
    chk("R1 err", {31'b0, mode_err_o}, 32'h0);
    for (int r = 0; r < 16; r++) begin
      rd_a_addr_i = 4'(r);
      rd_b_addr_i = 4'(15 - r);
      #1;
      chk("R1 read a", rd_a_data_o, 32'h0);
      chk("R1 read b", rd_b_data_o, 32'h0);
    end

    for (int i = 0; i < N_VEC; i++) begin
      @(negedge clk_i);
      mode_chg_i  = TBL[i].chg;
      mode_i      = TBL[i].mode;
      wr_en_i     = TBL[i].we;
      wr_addr_i   = TBL[i].wa;
      wr_data_i   = TBL[i].wd;
      rd_a_addr_i = TBL[i].ra;
      rd_b_addr_i = TBL[i].rb;
      @(posedge clk_i);
      #1;
      checks++;
      if (rd_a_data_o !== TBL[i].ea || rd_b_data_o !== TBL[i].eb ||
          mode_o !== TBL[i].em || mode_err_o !== TBL[i].ee) begin
        errors++;
        $display("FAIL R%0d step %0d act a=%h b=%h m=%h e=%b exp a=%h b=%h m=%h e=%b",
                 TBL[i].req, i, rd_a_data_o, rd_b_data_o, mode_o, mode_err_o,
                 TBL[i].ea, TBL[i].eb, TBL[i].em, TBL[i].ee);
      end
    end

    // R10: reads follow the address with no clock edge
    @(negedge clk_i);
    idle_inputs();
    rd_a_addr_i = 4'd0;
    #1 chk("R10 comb read r0", rd_a_data_o, 32'h55);
    rd_a_addr_i = 4'd15;
    #1 chk("R10 comb read r15", rd_a_data_o, 32'hF0);
    rd_b_addr_i = 4'd8;
    #1 chk("R10 comb read b r8", rd_b_data_o, 32'hA8);

    // R7: mode_i toggling without the strobe changes nothing
    mode_i = 5'h13;
    @(posedge clk_i);
    #1 chk("R7 no strobe", {27'b0, mode_o}, 32'h1F);

    // R1: a second reset clears error, mode and every bank
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1 chk("R1 async err clear", {31'b0, mode_err_o}, 32'h0);
    chk("R1 async mode", {27'b0, mode_o}, 32'h10);
    @(negedge clk_i);
    rst_ni = 1'b1;
    rd_a_addr_i = 4'd13;
    rd_b_addr_i = 4'd0;
    #1 chk("R1 r13 cleared", rd_a_data_o, 32'h0);
    chk("R1 r0 cleared", rd_b_data_o, 32'h0);
    @(negedge clk_i);
    mode_chg_i  = 1'b1;
    mode_i      = 5'h11;
    rd_a_addr_i = 4'd8;
    @(posedge clk_i);
    #1 chk("R1 fiq r8 cleared", rd_a_data_o, 32'h0);
    chk("R4 fiq entered", {27'b0, mode_o}, 32'h11);

    @(negedge clk_i);
    idle_inputs();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule